// File: doc/BRIEF.md
# Interrupt System Register Access Gate

This block decides, for each attempted access to an interrupt-controller system register, whether the access proceeds, is routed to the hypervisor level as a trap with a syndrome byte, or is treated as an undefined instruction. A requester presents the exception level, security state, register class, direction and the relevant control bits together with `req_valid`. One clock later the block reports a single verdict on `rsp_valid`, `outcome` and `syndrome`.

The policy has a fixed priority. Undefined checks come first: an unknown register class, any access from level 0, a level-1 access to the hypervisor control register, and a level-2 or level-3 access while that level's register-enable bit is clear. Trap checks come next. These apply only to non-secure level-1 accesses. Each register group has its own trap bit. Deactivate writes have an extra trap bit that affects writes only.

A two-state machine holds the verdict. In `ST_IDLE` no response is shown. The transition `IDLE_TO_REPLY` happens when a request is accepted. In `ST_REPLY` the verdict is presented for one cycle. From there the machine takes `REPLY_TO_REPLY` on another request or `REPLY_TO_IDLE` when no request arrives.

Top module: `irq_sysreg_gate`

## Requirements
- R1: After reset `rsp_valid` is 0, `outcome` is 2'b00 and `syndrome` is 8'h00.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high. When no request was made it is 0, and `outcome`/`syndrome` keep their last values.
- R3: Any access with `cur_el` = 0 gives `outcome` 2'b10 (undefined).
- R4: The class codes are: 0 control-register self, 1 group-0, 2 group-1, 3 common, 4 deactivate (DIR). A level-1 access to class 0 gives trap (2'b01) with `syndrome` 8'h03 when both `hyp_en` and `hyp_cp_trap` are 1. Otherwise it gives undefined.
- R5: A level-2 access to any valid class is undefined when `sre_hyp` is 0 and allowed (2'b00) otherwise. A level-3 access behaves the same way, using `sre_mon`.
- R6: A non-secure level-1 group-0 access traps with `syndrome` 8'h18 when `trap_grp0` is 1. A group-1 access traps in the same way when `trap_grp1` is 1. Otherwise these accesses are allowed.
- R7: A non-secure level-1 access to the common class (3) or the deactivate class (4) traps with 8'h18 when `trap_common` is 1.
- R8: A non-secure level-1 write to class 4 traps with 8'h18 when `trap_deact` is 1. A read of class 4 is not affected by `trap_deact`.
- R9: When `nonsecure` is 0, or at levels 2 and 3, the four trap bits have no effect. Valid non-self classes at secure level 1 are allowed.
- R10: Class codes 5 to 7 give undefined at every level.
- R11: `outcome` never takes the value 2'b11. `syndrome` is 8'h00 whenever the outcome is not trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access attempt presented this cycle |
| cur_el | input | 2 | Exception level of the access (0..3) |
| hyp_en | input | 1 | Hypervisor level enabled |
| hyp_cp_trap | input | 1 | Hypervisor coprocessor-register trap bit |
| sre_hyp | input | 1 | Level-2 system-register interface enable |
| sre_mon | input | 1 | Level-3 system-register interface enable |
| trap_grp0 | input | 1 | Trap level-1 group-0 accesses |
| trap_grp1 | input | 1 | Trap level-1 group-1 accesses |
| trap_common | input | 1 | Trap level-1 common-register accesses |
| trap_deact | input | 1 | Trap level-1 deactivate writes |
| nonsecure | input | 1 | Access is non-secure |
| reg_class | input | 3 | Register class code (see R4) |
| is_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Verdict valid this cycle |
| outcome | output | 2 | 00 allow, 01 trap, 10 undefined |
| syndrome | output | 8 | Trap syndrome, zero unless trapping |

## Verification
Assertions check the rules that hold at every clock edge. These are the one-cycle response timing, a legal outcome code, a zero syndrome outside traps, undefined for level 0 and for reserved classes, and the self-register rule at level 1. Only the bench scenarios show the full priority interplay. This covers the per-group trap routing, the write-only deactivate trap, and the secure-state and upper-level masking of the trap bits. The bench checks these against an independent model over random and directed inputs.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    typedef enum logic [1:0] {
        OUT_ALLOW = 2'b00,
        OUT_TRAP  = 2'b01,
        OUT_UNDEF = 2'b10
    } outcome_e;

    typedef enum logic [2:0] {
        CLS_SELF   = 3'd0,
        CLS_GRP0   = 3'd1,
        CLS_GRP1   = 3'd2,
        CLS_COMMON = 3'd3,
        CLS_DEACT  = 3'd4
    } reg_cls_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } gate_state_e;

    localparam int unsigned CLS_W = 3;
    localparam int unsigned NUM_CLS = 5;
endpackage

// File: rtl/irq_gate_classify.sv
module irq_gate_classify
    import irq_gate_pkg::*;
(
    input  logic [CLS_W-1:0] reg_class,
    input  logic             nonsecure,
    input  logic             is_write,
    input  logic             trap_grp0,
    input  logic             trap_grp1,
    input  logic             trap_common,
    input  logic             trap_deact,
    output logic             cls_self,
    output logic             cls_bad,
    output logic             grp_trap
);
    // per-class trap vector, one entry per valid class
    logic [NUM_CLS-1:0] hit_vec;

    always_comb begin
        hit_vec             = '0;
        hit_vec[CLS_GRP0]   = trap_grp0;
        hit_vec[CLS_GRP1]   = trap_grp1;
        hit_vec[CLS_COMMON] = trap_common;
        hit_vec[CLS_DEACT]  = trap_common | (is_write & trap_deact);
    end

    always_comb begin
        cls_bad  = (int'(reg_class) >= NUM_CLS);
        cls_self = (reg_class == CLS_SELF);
        grp_trap = 1'b0;
        if (!cls_bad && nonsecure)
            grp_trap = hit_vec[reg_class];
    end
endmodule

// File: rtl/irq_gate_policy.sv
module irq_gate_policy
    import irq_gate_pkg::*;
#(
    parameter int unsigned SYN_W    = 8,
    parameter logic [SYN_W-1:0] SYN_SELF = 8'h03,
    parameter logic [SYN_W-1:0] SYN_GRP  = 8'h18
) (
    input  logic [1:0]       cur_el,
    input  logic             hyp_en,
    input  logic             hyp_cp_trap,
    input  logic             sre_hyp,
    input  logic             sre_mon,
    input  logic             cls_self,
    input  logic             cls_bad,
    input  logic             grp_trap,
    output outcome_e         verdict,
    output logic [SYN_W-1:0] verdict_syn
);
    always_comb begin
        verdict     = OUT_ALLOW;
        verdict_syn = '0;
        if (cls_bad) begin
            verdict = OUT_UNDEF;
        end else begin
            unique case (cur_el)
                2'd0: verdict = OUT_UNDEF;
                2'd1: begin
                    if (cls_self) begin
                        if (hyp_en && hyp_cp_trap) begin
                            verdict     = OUT_TRAP;
                            verdict_syn = SYN_SELF;
                        end else begin
                            verdict = OUT_UNDEF;
                        end
                    end else if (grp_trap) begin
                        verdict     = OUT_TRAP;
                        verdict_syn = SYN_GRP;
                    end
                end
                2'd2: verdict = sre_hyp ? OUT_ALLOW : OUT_UNDEF;
                2'd3: verdict = sre_mon ? OUT_ALLOW : OUT_UNDEF;
                default: verdict = OUT_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/irq_sysreg_gate.sv
module irq_sysreg_gate
    import irq_gate_pkg::*;
#(
    parameter int unsigned SYN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       cur_el,
    input  logic             hyp_en,
    input  logic             hyp_cp_trap,
    input  logic             sre_hyp,
    input  logic             sre_mon,
    input  logic             trap_grp0,
    input  logic             trap_grp1,
    input  logic             trap_common,
    input  logic             trap_deact,
    input  logic             nonsecure,
    input  logic [2:0]       reg_class,
    input  logic             is_write,
    output logic             rsp_valid,
    output logic [1:0]       outcome,
    output logic [SYN_W-1:0] syndrome
);
    logic             cls_self, cls_bad, grp_trap;
    outcome_e         verdict;
    logic [SYN_W-1:0] verdict_syn;
    gate_state_e      state_q, state_d;
    outcome_e         out_q;
    logic [SYN_W-1:0] syn_q;

    irq_gate_classify u_cls (
        .reg_class  (reg_class),
        .nonsecure  (nonsecure),
        .is_write   (is_write),
        .trap_grp0  (trap_grp0),
        .trap_grp1  (trap_grp1),
        .trap_common(trap_common),
        .trap_deact (trap_deact),
        .cls_self   (cls_self),
        .cls_bad    (cls_bad),
        .grp_trap   (grp_trap)
    );

    irq_gate_policy #(.SYN_W(SYN_W), .SYN_SELF(SYN_W'(8'h03)), .SYN_GRP(SYN_W'(8'h18))) u_pol (
        .cur_el     (cur_el),
        .hyp_en     (hyp_en),
        .hyp_cp_trap(hyp_cp_trap),
        .sre_hyp    (sre_hyp),
        .sre_mon    (sre_mon),
        .cls_self   (cls_self),
        .cls_bad    (cls_bad),
        .grp_trap   (grp_trap),
        .verdict    (verdict),
        .verdict_syn(verdict_syn)
    );

    // next-state: IDLE_TO_REPLY, REPLY_TO_REPLY, REPLY_TO_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = req_valid ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= OUT_ALLOW;
            syn_q <= '0;
        end else if (req_valid) begin
            out_q <= verdict;
            syn_q <= verdict_syn;
        end
    end

    assign rsp_valid = (state_q == ST_REPLY);
    assign outcome   = out_q;
    assign syndrome  = syn_q;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(outcome) && $stable(syndrome)));
    p_el0_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_el == 2'd0) |=> outcome == OUT_UNDEF);
    p_self_l1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_el == 2'd1 && reg_class == 3'd0)
        |=> ((outcome == OUT_TRAP && syndrome == SYN_W'(8'h03)) || outcome == OUT_UNDEF));
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && reg_class > 3'd4) |=> outcome == OUT_UNDEF);
    p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        outcome != 2'b11);
    p_syn_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && outcome != OUT_TRAP) |-> syndrome == '0);
endmodule

// File: tb/tb_irq_sysreg_gate.sv
module tb_irq_sysreg_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] cur_el = '0;
    logic       hyp_en = 0, hyp_cp_trap = 0, sre_hyp = 0, sre_mon = 0;
    logic       trap_grp0 = 0, trap_grp1 = 0, trap_common = 0, trap_deact = 0;
    logic       nonsecure = 0, is_write = 0;
    logic [2:0] reg_class = '0;
    logic       rsp_valid;
    logic [1:0] outcome;
    logic [7:0] syndrome;
    int         n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    irq_sysreg_gate dut (.*);

    function automatic logic [9:0] model();
        logic [1:0] o; logic [7:0] s; logic hit;
        o = 2'b00; s = 8'h00;
        if (reg_class > 3'd4)   o = 2'b10;                       // R10
        else if (cur_el == 2'd0) o = 2'b10;                      // R3
        else if (cur_el == 2'd1) begin
            if (reg_class == 3'd0) begin                          // R4
                if (hyp_en && hyp_cp_trap) begin o = 2'b01; s = 8'h03; end
                else o = 2'b10;
            end else if (nonsecure) begin                         // R6 R7 R8 R9
                case (reg_class)
                    3'd1: hit = trap_grp0;
                    3'd2: hit = trap_grp1;
                    3'd3: hit = trap_common;
                    default: hit = trap_common || (is_write && trap_deact);
                endcase
                if (hit) begin o = 2'b01; s = 8'h18; end
            end
        end else if (cur_el == 2'd2) o = sre_hyp ? 2'b00 : 2'b10; // R5
        else o = sre_mon ? 2'b00 : 2'b10;
        return {o, s};
    endfunction

    task automatic check(string req, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(string req);
        logic [9:0] exp;
        @(negedge clk);
        req_valid = 1'b1;
        exp = model();
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R2 valid"}, {9'd0, rsp_valid}, 10'd1);
        check(req, {outcome, syndrome}, exp);
        check("R11 code", {8'd0, outcome == 2'b11}, 10'd0);
    endtask

    task automatic set_l1(logic [2:0] c, logic ns, logic wr);
        cur_el = 2'd1; reg_class = c; nonsecure = ns; is_write = wr;
    endtask

    initial begin
        #400000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset", {rsp_valid, outcome, syndrome, 1'b0}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {rsp_valid, outcome, syndrome, 1'b0}, '0);

        cur_el = 2'd0; reg_class = 3'd3; issue("R3 el0");
        cur_el = 2'd0; reg_class = 3'd0; sre_hyp = 1; sre_mon = 1; issue("R3 el0 self");
        set_l1(3'd0, 1, 0); hyp_en = 1; hyp_cp_trap = 1; issue("R4 self trap");
        hyp_cp_trap = 0; issue("R4 self undef");
        hyp_en = 0; hyp_cp_trap = 1; issue("R4 self no hyp");
        cur_el = 2'd2; sre_hyp = 0; reg_class = 3'd2; issue("R5 el2 undef");
        sre_hyp = 1; issue("R5 el2 allow");
        cur_el = 2'd3; sre_mon = 0; issue("R5 el3 undef");
        sre_mon = 1; issue("R5 el3 allow");
        trap_grp0 = 1; set_l1(3'd1, 1, 0); issue("R6 grp0 trap");
        trap_grp0 = 0; trap_grp1 = 1; issue("R6 grp0 allow");
        set_l1(3'd2, 1, 1); issue("R6 grp1 trap");
        trap_grp1 = 0; trap_common = 1; set_l1(3'd3, 1, 0); issue("R7 common trap");
        set_l1(3'd4, 1, 0); issue("R7 dir via common");
        trap_common = 0; trap_deact = 1; set_l1(3'd4, 1, 1); issue("R8 dir write trap");
        set_l1(3'd4, 1, 0); issue("R8 dir read allowed");
        trap_grp0 = 1; trap_grp1 = 1; trap_common = 1;
        set_l1(3'd4, 0, 1); issue("R9 secure ignores");
        set_l1(3'd1, 0, 0); issue("R9 secure grp0");
        cur_el = 2'd2; nonsecure = 1; issue("R9 el2 ignores");
        cur_el = 2'd3; reg_class = 3'd4; is_write = 1; issue("R9 el3 ignores");
        reg_class = 3'd6; issue("R10 reserved el3");
        set_l1(3'd7, 1, 1); issue("R10 reserved el1");

        @(negedge clk);
        check("R2 idle drop", {9'd0, rsp_valid}, 10'd0);
        check("R2 hold", {outcome, 8'd0}, {2'b10, 8'd0});

        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom();
            cur_el = r[1:0]; hyp_en = r[2]; hyp_cp_trap = r[3];
            sre_hyp = r[4]; sre_mon = r[5]; trap_grp0 = r[6]; trap_grp1 = r[7];
            trap_common = r[8]; trap_deact = r[9]; nonsecure = r[10];
            is_write = r[11]; reg_class = (r[14:12] == 3'd7 && r[15]) ? 3'd4 : r[14:12];
            issue("R11 random");
            if (outcome != 2'b01)
                check("R11 syndrome zero", {2'b00, syndrome}, 10'd0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule